// File: doc/BRIEF.md
# Johnson-Coded Dual-Clock Flit FIFO

This block moves network flits from one clock island to another when the two clocks are unrelated. A producer in the write domain offers a flit with a valid/ready handshake. A consumer in the read domain takes flits through a second valid/ready handshake. Each side has its own small port controller, and both controllers work only from registers in their own domain.

Each side keeps its position in the ring as a Johnson (twisted-ring) counter that is DEPTH bits wide and has 2*DEPTH states. Exactly one bit changes on each step, so the pointer can cross into the other domain through a plain multi-flop synchronizer with no binary or Gray conversion. Emptiness is decided on the read side and fullness on the write side, each against a delayed copy of the other side's pointer. Both decisions are conservative and never unsafe.

Top module: `jc_bisync_fifo`

## Requirements
- R1: While the reset of its domain is held low, the write side presents wr_ready=1 and the read side presents rd_valid=0 within one clock of that domain. Both pointers reset to all zeros, so the FIFO comes out of reset empty.
- R2: Every flit accepted at the write port (wr_valid=1 and wr_ready=1 at a wr_clk rising edge) is delivered exactly once at the read port (rd_valid=1 and rd_ready=1 at an rd_clk rising edge), in acceptance order and with all FLIT_W bits unchanged.
- R3: With no reads, exactly DEPTH writes are accepted. wr_ready drops at the wr_clk edge that accepts the DEPTH-th write, so the FIFO never holds more than DEPTH flits.
- R4: A write offered while wr_ready=0 is ignored. It leaves the write pointer and the stored contents unchanged, and it is never delivered later.
- R5: A read offered while rd_valid=0 is ignored. It leaves the read pointer unchanged, so the next flit written is the next flit delivered.
- R6: wr_ready falls only at an edge where a write was accepted, and rd_valid falls only at an edge where a read was accepted. A full FIFO that has been drained shows wr_ready=1 again.
- R7: Each pointer only ever holds a legal Johnson pattern, one that has at most one boundary between a run of ones and a run of zeros. Any other pattern is replaced by all zeros at the next clock.
- R8: After a flit is written into an empty FIFO, rd_valid rises within SYNC_STAGES+3 rd_clk cycles. The write pointer passes through SYNC_STAGES flops, at least two, in the read domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous active-low reset |
| wr_valid | input | 1 | Producer offers a flit |
| wr_ready | output | 1 | FIFO can accept a flit (not full) |
| wr_flit | input | FLIT_W | Flit offered by the producer |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous active-low reset |
| rd_valid | output | 1 | A flit is available (not empty) |
| rd_ready | input | 1 | Consumer takes the flit this cycle |
| rd_flit | output | FLIT_W | Oldest stored flit |

## Verification
The bench fills the FIFO with reads held off. A full test that compared against the raw pointer rather than the pointer advanced by DEPTH would accept one flit too many or stop early, and the count of accepted writes exposes either fault. It then keeps offering writes while full and reads while empty. A controller that let those attempts move a pointer would deliver a stale or extra flit, or skip the next real one, and the drain afterwards shows it. A randomized phase with two unrelated clocks, some bursts and some sparse traffic, catches a wrong slot decode or a lost wrap at the Johnson half-cycle, where the counter turns from all ones back toward zeros and the data order or value would break.

// File: rtl/jc_fifo_pkg.sv
// Shared helpers for the Johnson-coded FIFO.
// Assumes pointer widths of 2..64 bits; callers zero-extend to 64.
package jc_fifo_pkg;

    localparam int JC_MAX_W = 64;

    // True when q[w-1:0] has at most one 0/1 boundary (a legal twisted-ring state).
    function automatic logic jc_legal(input logic [JC_MAX_W-1:0] q, input int w);
        int edges;
        edges = 0;
        for (int i = 0; i < JC_MAX_W - 1; i++) begin
            if (i < w - 1 && q[i] != q[i+1]) edges++;
        end
        return (edges <= 1);
    endfunction

    // Storage slot (state index modulo w) addressed by a legal Johnson state.
    function automatic int jc_slot(input logic [JC_MAX_W-1:0] q, input int w);
        int ones;
        ones = 0;
        for (int i = 0; i < JC_MAX_W; i++) begin
            if (i < w && q[i]) ones++;
        end
        if (q[w-1]) return (ones == w) ? 0 : (w - ones);
        return ones;
    endfunction

endpackage

// File: rtl/jc_ptr.sv
// Johnson pointer: DEPTH-bit twisted-ring counter with 2*DEPTH states.
// Steps when 'step' is high; an illegal pattern is forced to all zeros.
// Assumes DEPTH >= 2. Synchronous active-low reset.
module jc_ptr #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [DEPTH-1:0] q
);
    import jc_fifo_pkg::*;

    logic legal;

    // Purpose: flag a state outside the twisted-ring sequence.
    always_comb begin
        legal = jc_legal(64'(q), DEPTH);
    end

    // Purpose: advance the ring, recovering to zero from an illegal state.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (!legal)  q <= '0;
        else if (step)    q <= {q[DEPTH-2:0], ~q[DEPTH-1]};
    end
endmodule

// File: rtl/jc_sync.sv
// Multi-flop synchronizer for a vector whose value changes by at most one bit per step.
// Assumes STAGES >= 2. Synchronous active-low reset in the destination domain.
module jc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Purpose: first flop catches the foreign value.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Purpose: each further flop lets metastability settle.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/jc_flit_ram.sv
// Flit storage: DEPTH entries, one write port on the write clock, one
// combinational read port. Assumes the controllers never write an unread slot.
module jc_flit_ram #(
    parameter int FLIT_W = 32,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_slot,
    input  logic [FLIT_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_slot,
    output logic [FLIT_W-1:0] rd_data
);
    logic [FLIT_W-1:0] cells [DEPTH];

    // Purpose: store the accepted flit.
    always_ff @(posedge wr_clk) begin
        if (wr_en) cells[wr_slot] <= wr_data;
    end

    assign rd_data = cells[rd_slot];
endmodule

// File: rtl/jc_port.sv
// Port controller for one side of the FIFO. It owns the local Johnson pointer,
// synchronizes the far pointer and decides availability:
//   write side: ready unless far == ~local (local is DEPTH steps ahead: full)
//   read side : valid unless far == local (empty)
// Assumes far_ptr changes one bit per step. Synchronous active-low reset.
module jc_port #(
    parameter int DEPTH   = 8,
    parameter int STAGES  = 2,
    parameter bit WR_SIDE = 1'b1,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [DEPTH-1:0] far_ptr,
    output logic             avail,
    output logic             fire,
    output logic [DEPTH-1:0] ptr,
    output logic [AW-1:0]    slot
);
    import jc_fifo_pkg::*;

    logic [DEPTH-1:0] far_s;

    jc_sync #(.W(DEPTH), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (far_ptr),
        .q     (far_s)
    );

    if (WR_SIDE) begin : g_full
        // Purpose: advancing a Johnson state by DEPTH steps inverts it.
        always_comb avail = (far_s != ~ptr);
    end else begin : g_empty
        // Purpose: equal pointers mean nothing left to read.
        always_comb avail = (far_s != ptr);
    end

    assign fire = req && avail;

    jc_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (fire),
        .q     (ptr)
    );

    // Purpose: map the pointer state to its storage slot.
    always_comb slot = AW'(jc_slot(64'(ptr), DEPTH));
endmodule

// File: rtl/jc_bisync_fifo.sv
// Dual-clock flit FIFO with Johnson-coded pointers crossing between domains.
// Assumes 2 <= DEPTH <= 64, SYNC_STAGES >= 2, each reset synchronous to its clock.
module jc_bisync_fifo #(
    parameter int FLIT_W      = 32,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [FLIT_W-1:0] wr_flit,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [FLIT_W-1:0] rd_flit
);
    logic [DEPTH-1:0] wr_ptr;
    logic [DEPTH-1:0] rd_ptr;
    logic [AW-1:0]    wr_slot;
    logic [AW-1:0]    rd_slot;
    logic             wr_fire;
    logic             rd_fire;

    jc_port #(.DEPTH(DEPTH), .STAGES(SYNC_STAGES), .WR_SIDE(1'b1)) u_wr_port (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .req     (wr_valid),
        .far_ptr (rd_ptr),
        .avail   (wr_ready),
        .fire    (wr_fire),
        .ptr     (wr_ptr),
        .slot    (wr_slot)
    );

    jc_port #(.DEPTH(DEPTH), .STAGES(SYNC_STAGES), .WR_SIDE(1'b0)) u_rd_port (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .req     (rd_ready),
        .far_ptr (wr_ptr),
        .avail   (rd_valid),
        .fire    (rd_fire),
        .ptr     (rd_ptr),
        .slot    (rd_slot)
    );

    jc_flit_ram #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_ram (
        .wr_clk  (wr_clk),
        .wr_en   (wr_fire),
        .wr_slot (wr_slot),
        .wr_data (wr_flit),
        .rd_slot (rd_slot),
        .rd_data (rd_flit)
    );
endmodule

// File: rtl/jc_bisync_fifo_chk.sv
// Checker for jc_bisync_fifo, attached with bind. Observes ports and pointers only.
module jc_bisync_fifo_chk #(
    parameter int DEPTH = 8
) (
    input logic             wr_clk,
    input logic             wr_rst_n,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [DEPTH-1:0] wptr,
    input logic [DEPTH-1:0] rptr
);
    import jc_fifo_pkg::*;

    p_reset_ready_r1: assert property (@(posedge wr_clk) !wr_rst_n |=> wr_ready);
    p_reset_empty_r1: assert property (@(posedge rd_clk) !rd_rst_n |=> !rd_valid);

    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wptr == ~rptr) |-> !wr_ready);

    p_full_hold_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_valid && !wr_ready) |=> $stable(wptr));

    p_no_underflow_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rptr == wptr) |-> !rd_valid);

    p_empty_hold_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_ready && !rd_valid) |=> $stable(rptr));

    p_full_by_write_r6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $fell(wr_ready) |-> $past(wr_valid));

    p_empty_by_read_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $fell(rd_valid) |-> $past(rd_ready));

    p_wptr_legal_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        jc_legal(64'(wptr), DEPTH));

    p_rptr_legal_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        jc_legal(64'(rptr), DEPTH));
endmodule

bind jc_bisync_fifo jc_bisync_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .wptr     (wr_ptr),
    .rptr     (rd_ptr)
);

// File: tb/jc_bisync_fifo_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// scored against a queue model of the requirements.
module jc_bisync_fifo_tb_top;
    localparam int W     = 32;
    localparam int DEPTH = 8;
    localparam int SYNC  = 2;
    localparam int NRAND = 400;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [W-1:0]  wr_flit = '0;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [W-1:0]  rd_flit;

    int            n_checks = 0;
    int            n_fail   = 0;
    logic [W-1:0]  model_q[$];

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    jc_bisync_fifo #(.FLIT_W(W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC)) dut_i (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_flit  (wr_flit),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready),
        .rd_flit  (rd_flit)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one write-side cycle; the transfer happens at the next rising edge.
    task automatic wr_step(input logic v, input logic [W-1:0] d, output bit took);
        @(negedge wr_clk);
        wr_valid = v;
        wr_flit  = d;
        took = v && wr_ready;
        if (took) model_q.push_back(d);
    endtask

    // Drive one read-side cycle and score any flit taken at the next rising edge.
    task automatic rd_step(input logic r, input string tag, output bit got);
        @(negedge rd_clk);
        rd_ready = r;
        got = r && rd_valid;
        if (got) begin
            if (model_q.size() == 0) check(1'b0, tag, rd_flit, '0);
            else begin
                logic [W-1:0] e;
                e = model_q.pop_front();
                check(rd_flit == e, tag, rd_flit, e);
            end
        end
    endtask

    function automatic bit coin(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    initial begin
        repeat (150000) @(posedge wr_clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        bit took, got;
        int acc, lat;
        void'($urandom(32'd20240611));

        repeat (10) @(negedge wr_clk);
        // R1: state while reset is held
        check(wr_ready == 1'b1, "R1 wr_ready in reset", W'(wr_ready), 1);
        check(rd_valid == 1'b0, "R1 rd_valid in reset", W'(rd_valid), 0);
        @(negedge wr_clk); wr_rst_n = 1'b1;
        @(negedge rd_clk); rd_rst_n = 1'b1;
        repeat (4) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R1 empty after reset", W'(rd_valid), 0);

        // R5: reads offered while empty must be ignored
        acc = 0;
        for (int i = 0; i < 6; i++) begin
            rd_step(1'b1, "R5", got);
            if (got) acc++;
        end
        check(acc == 0, "R5 no read while empty", W'(acc), 0);
        rd_step(1'b0, "R5", got);
        wr_step(1'b1, 32'hA5A5_0001, took);
        wr_step(1'b0, '0, took);
        // R8: rd_valid must appear within SYNC+3 read cycles
        lat = 0;
        while (!rd_valid && lat < 20) begin
            @(negedge rd_clk); lat++;
        end
        check(lat <= SYNC + 3, "R8 empty-to-valid latency", W'(lat), W'(SYNC + 3));
        rd_step(1'b1, "R5 next flit after ignored reads", got);
        check(got, "R5 flit delivered", W'(got), 1);
        rd_step(1'b0, "R5", got);
        repeat (6) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R5 no extra flit", W'(rd_valid), 0);

        // R3: fill with reads held off
        acc = 0;
        for (int i = 0; i < 2 * DEPTH && (i == 0 || wr_ready); i++) begin
            wr_step(1'b1, 32'hF000_0000 + W'(i), took);
            if (took) acc++;
        end
        @(negedge wr_clk);
        check(acc == DEPTH, "R3 writes accepted until full", W'(acc), W'(DEPTH));
        check(wr_ready == 1'b0, "R3 wr_ready low when full", W'(wr_ready), 0);
        // R4: writes while full are ignored
        acc = 0;
        for (int i = 0; i < 12; i++) begin
            wr_step(1'b1, 32'hDEAD_0000 + W'(i), took);
            if (took) acc++;
        end
        wr_step(1'b0, '0, took);
        check(acc == 0, "R4 no write accepted while full", W'(acc), 0);
        acc = 0;
        for (int i = 0; i < 40 && model_q.size() > 0; i++) begin
            rd_step(1'b1, "R4 drain after full", got);
            if (got) acc++;
        end
        rd_step(1'b0, "R4", got);
        check(acc == DEPTH, "R4 drain count", W'(acc), W'(DEPTH));
        repeat (6) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R4 ignored writes not delivered", W'(rd_valid), 0);
        repeat (6) @(negedge wr_clk);
        check(wr_ready == 1'b1, "R6 ready again after drain", W'(wr_ready), 1);

        // R2: burst traffic then random traffic on unrelated clocks
        for (int phase = 0; phase < 2; phase++) begin
            fork
                begin
                    int n;
                    bit t;
                    n = 0;
                    while (n < NRAND) begin
                        wr_step(phase == 0 ? 1'b1 : coin(60), $urandom, t);
                        if (t) n++;
                    end
                    wr_step(1'b0, '0, t);
                end
                begin
                    int m;
                    bit g;
                    m = 0;
                    while (m < NRAND) begin
                        rd_step(phase == 0 ? 1'b1 : coin(50), "R2 order and data", g);
                        if (g) m++;
                    end
                    rd_step(1'b0, "R2", g);
                end
            join
        end
        repeat (6) @(negedge rd_clk);
        check(model_q.size() == 0, "R2 every flit delivered", W'(model_q.size()), 0);
        check(rd_valid == 1'b0, "R2 empty at end", W'(rd_valid), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule